// File: doc/BRIEF.md
# SD Host Write Block-Gap Sequencer

This block sequences the write direction of an SD/MMC-style host controller across a multi-block transfer. A start strobe loads the block count and raises two present-state bits: write-transfer-active and data-line-active. The data path reports each finished block on one strobe and the start of the next block on another. The block keeps the remaining block count and knows when the line sits in a gap between blocks.

Software can ask the transfer to halt at the next block gap. The block honours that request only in a gap and only once the write buffer has drained. It then drops write-transfer-active and flags a block-gap event. Once the card releases busy, it drops data-line-active and flags transfer-complete. A request made during the final block has no effect, and the transfer ends normally. A continue write resumes a halted transfer. Completion flags are sticky and are cleared by writing 1 to them. Acknowledging transfer-complete also clears the stop request.

Top module: `sdwr_gap_ctrl`

## Requirements
- R1: A pending stop request is accepted only at a clock edge where the sequencer is running, is between blocks (a block-done strobe has been seen and the next block-begin strobe has not), and `wbuf_valid_i` is 0. While `wbuf_valid_i` is 1 the transfer keeps running.
- R2: On the edge that accepts a stop, `wr_active_o` goes to 0, `gap_evt_o` goes to 1, and `dat_active_o` stays 1.
- R3: After an accepted stop, `dat_active_o` stays 1 while `card_busy_i` is 1. On the first edge that sees `card_busy_i` at 0, `dat_active_o` goes to 0 and `xfer_cmp_o` goes to 1.
- R4: `stop_req_o` takes `stop_wdata_i` on every edge where `stop_wr_i` is 1. Otherwise it is cleared only on an edge where `irq_clr_i[1]` is 1 while `xfer_cmp_o` is 1, and it holds in every other case.
- R5: A stop request that is pending during the last block is not accepted. The last block-done strobe ends the transfer with `gap_evt_o` left at 0.
- R6: A continue write (`cont_wr_i`) has no effect unless the transfer is halted after an accepted stop and `stop_req_o` is 0. In particular it has no effect while idle or while the stop request is still 1.
- R7: An accepted continue sets `wr_active_o` and `dat_active_o` to 1 on the next edge. No continue state is kept. The transfer then ends after exactly the blocks that were still remaining.
- R8: On the edge that takes the block-done strobe of the last block, `wr_active_o` goes to 0 with no block-gap event. Data-line-active then falls and `xfer_cmp_o` rises on the first edge that sees `card_busy_i` at 0.
- R9: The interrupt flags are sticky. A 1 on `irq_clr_i[0]` clears `gap_evt_o`, and a 1 on `irq_clr_i[1]` clears `xfer_cmp_o`. Each bit clears only its own flag, and a set on the same edge wins over a clear.
- R10: `start_i` loads `blk_cnt_i` and sets both active bits on the next edge. It is ignored while `dat_active_o` is 1 and when `blk_cnt_i` is 0.
- R11: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe for a new write transfer |
| blk_cnt_i | input | CNT_W | Block count loaded on start |
| blk_begin_i | input | 1 | Next block begins on the data line |
| blk_done_i | input | 1 | Current block finished |
| wbuf_valid_i | input | 1 | Write data still held in the controller |
| card_busy_i | input | 1 | Card busy signal |
| stop_wr_i | input | 1 | Register write to the stop request bit |
| stop_wdata_i | input | 1 | Value written to the stop request bit |
| cont_wr_i | input | 1 | Write of 1 to the self-clearing continue bit |
| irq_clr_i | input | 2 | Write-1-to-clear: bit 0 gap event, bit 1 transfer complete |
| wr_active_o | output | 1 | Write-transfer-active status |
| dat_active_o | output | 1 | Data-line-active status |
| stop_req_o | output | 1 | Stop-at-gap request bit |
| gap_evt_o | output | 1 | Block-gap event flag |
| xfer_cmp_o | output | 1 | Transfer-complete flag |

## Verification
The assertions assume that only an accepted stop can raise the block-gap flag, and that the data path sends block-done strobes only while a block is on the line and block-begin strobes only in a gap. The bench drives every strobe for exactly one cycle and in that legal order, and keeps buffer-valid and busy steady across the edges where they are checked. Under those conditions, a rising gap flag can be traced to an empty buffer, and a falling data-line bit can be traced to a released busy.

// File: rtl/sdwr_pkg.sv
package sdwr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_XFER,
        ST_DRAIN,
        ST_HALTED,
        ST_FINISH
    } seq_state_e;

    localparam int IRQ_N   = 2;
    localparam int IRQ_GAP = 0;
    localparam int IRQ_CMP = 1;
endpackage

// File: rtl/sdwr_blk_track.sv
module sdwr_blk_track #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             dec_i,
    input  logic             begin_i,
    output logic             at_gap_o,
    output logic             last_o
);
    typedef struct packed {
        logic [CNT_W-1:0] rem;
        logic             gap;
    } trk_t;

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        if (load_i) begin
            trk_d.rem = load_val_i;
            trk_d.gap = 1'b0;
        end else if (dec_i) begin
            trk_d.rem = trk_q.rem - ONE;
            trk_d.gap = (trk_q.rem != ONE);
        end else if (begin_i) begin
            trk_d.gap = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign at_gap_o = trk_q.gap;
    assign last_o   = (trk_q.rem == ONE);
endmodule

// File: rtl/sdwr_irq_flags.sv
module sdwr_irq_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    logic [N-1:0] flag_d, flag_q;

    for (genvar gi = 0; gi < N; gi++) begin : g_flag
        always_comb begin
            flag_d[gi] = set_i[gi] | (flag_q[gi] & ~clr_i[gi]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/sdwr_gap_ctrl.sv
module sdwr_gap_ctrl
    import sdwr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] blk_cnt_i,
    input  logic             blk_begin_i,
    input  logic             blk_done_i,
    input  logic             wbuf_valid_i,
    input  logic             card_busy_i,
    input  logic             stop_wr_i,
    input  logic             stop_wdata_i,
    input  logic             cont_wr_i,
    input  logic [1:0]       irq_clr_i,
    output logic             wr_active_o,
    output logic             dat_active_o,
    output logic             stop_req_o,
    output logic             gap_evt_o,
    output logic             xfer_cmp_o
);
    typedef struct packed {
        seq_state_e state;
        logic       wr;
        logic       dat;
        logic       stop;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             at_gap, last_blk;
    logic             in_xfer, done_ok, end_now, stop_ok;
    logic             start_ok, cont_ok, begin_ok, drain_end, cmp_ack;
    logic [IRQ_N-1:0] irq_set, irq_flag;

    assign in_xfer   = (ctl_q.state == ST_XFER);
    assign done_ok   = in_xfer && !at_gap && blk_done_i;
    assign end_now   = done_ok && last_blk;
    assign stop_ok   = in_xfer && at_gap && ctl_q.stop && !wbuf_valid_i;
    assign begin_ok  = in_xfer && at_gap && blk_begin_i;
    assign start_ok  = start_i && !ctl_q.dat && (blk_cnt_i != '0);
    assign cont_ok   = cont_wr_i && (ctl_q.state == ST_HALTED) && !ctl_q.stop;
    assign drain_end = ((ctl_q.state == ST_DRAIN) || (ctl_q.state == ST_FINISH))
                       && !card_busy_i;
    assign cmp_ack   = irq_clr_i[IRQ_CMP] && irq_flag[IRQ_CMP];

    sdwr_blk_track #(.CNT_W(CNT_W)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (start_ok),
        .load_val_i (blk_cnt_i),
        .dec_i      (done_ok),
        .begin_i    (begin_ok),
        .at_gap_o   (at_gap),
        .last_o     (last_blk)
    );

    always_comb begin
        irq_set          = '0;
        irq_set[IRQ_GAP] = stop_ok;
        irq_set[IRQ_CMP] = drain_end;
    end

    sdwr_irq_flags #(.N(IRQ_N)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (irq_set),
        .clr_i  (irq_clr_i),
        .flag_o (irq_flag)
    );

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.state)
            ST_IDLE, ST_HALTED: begin
                if (start_ok || cont_ok) begin
                    ctl_d.state = ST_XFER;
                    ctl_d.wr    = 1'b1;
                    ctl_d.dat   = 1'b1;
                end
            end
            ST_XFER: begin
                if (end_now) begin
                    ctl_d.state = ST_FINISH;
                    ctl_d.wr    = 1'b0;
                end else if (stop_ok) begin
                    ctl_d.state = ST_DRAIN;
                    ctl_d.wr    = 1'b0;
                end
            end
            ST_DRAIN: begin
                if (drain_end) begin
                    ctl_d.state = ST_HALTED;
                    ctl_d.dat   = 1'b0;
                end
            end
            ST_FINISH: begin
                if (drain_end) begin
                    ctl_d.state = ST_IDLE;
                    ctl_d.dat   = 1'b0;
                end
            end
            default: ctl_d = '0;
        endcase

        if (stop_wr_i)    ctl_d.stop = stop_wdata_i;
        else if (cmp_ack) ctl_d.stop = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign wr_active_o  = ctl_q.wr;
    assign dat_active_o = ctl_q.dat;
    assign stop_req_o   = ctl_q.stop;
    assign gap_evt_o    = irq_flag[IRQ_GAP];
    assign xfer_cmp_o   = irq_flag[IRQ_CMP];
endmodule

// File: rtl/sdwr_gap_ctrl_chk.sv
module sdwr_gap_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic wbuf_valid_i,
    input logic card_busy_i,
    input logic wr_active_o,
    input logic dat_active_o,
    input logic gap_evt_o,
    input logic xfer_cmp_o
);
    p_gap_empty_buf_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gap_evt_o) |-> $past(!wbuf_valid_i));

    p_gap_drops_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gap_evt_o) |-> (!wr_active_o && dat_active_o && $past(wr_active_o)));

    p_dat_waits_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dat_active_o) |-> ($past(!card_busy_i) && xfer_cmp_o));

    p_wr_falls_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_active_o) |-> dat_active_o);

    p_wr_within_dat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_active_o |-> dat_active_o);
endmodule

bind sdwr_gap_ctrl sdwr_gap_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wbuf_valid_i (wbuf_valid_i),
    .card_busy_i  (card_busy_i),
    .wr_active_o  (wr_active_o),
    .dat_active_o (dat_active_o),
    .gap_evt_o    (gap_evt_o),
    .xfer_cmp_o   (xfer_cmp_o)
);

// File: tb/sdwr_gap_ctrl_tb.sv
`timescale 1ns/100ps
module sdwr_gap_ctrl_tb;
    localparam int CNT_W = 8;
    localparam int NVEC  = 5;
    // each row: block count, block during which stop is written (0 = none), busy cycles
    localparam int VEC [NVEC][3] = '{
        '{3, 0, 2},
        '{4, 2, 3},
        '{2, 2, 1},
        '{5, 1, 0},
        '{1, 1, 2}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 0, blk_begin_i = 0, blk_done_i = 0, wbuf_valid_i = 0;
    logic card_busy_i = 0, stop_wr_i = 0, stop_wdata_i = 0, cont_wr_i = 0;
    logic [CNT_W-1:0] blk_cnt_i = '0;
    logic [1:0] irq_clr_i = '0;
    logic wr_active_o, dat_active_o, stop_req_o, gap_evt_o, xfer_cmp_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    sdwr_gap_ctrl #(.CNT_W(CNT_W)) u_dut (
        .clk, .rst_n, .start_i, .blk_cnt_i, .blk_begin_i, .blk_done_i,
        .wbuf_valid_i, .card_busy_i, .stop_wr_i, .stop_wdata_i, .cont_wr_i,
        .irq_clr_i, .wr_active_o, .dat_active_o, .stop_req_o, .gap_evt_o,
        .xfer_cmp_o
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wait_busy_end(input int busy_cyc, input string tag);
        for (int j = 0; j < busy_cyc; j++) begin
            step();
            chk({tag, " dat held while busy"}, dat_active_o, 1'b1);
        end
        card_busy_i = 0;
        step();
        chk({tag, " dat cleared"}, dat_active_o, 1'b0);
        chk({tag, " xfer_cmp set"}, xfer_cmp_o, 1'b1);
    endtask

    task automatic run_xfer(input int cnt, input int stop_blk, input int busy_cyc);
        start_i = 1; blk_cnt_i = CNT_W'(cnt); card_busy_i = (busy_cyc > 0);
        step();
        start_i = 0;
        chk("R10 start wr", wr_active_o, 1'b1);
        chk("R10 start dat", dat_active_o, 1'b1);
        for (int i = 1; i <= cnt; i++) begin
            if (i > 1) begin
                blk_begin_i = 1; step(); blk_begin_i = 0;
            end
            if (i == stop_blk) begin
                stop_wr_i = 1; stop_wdata_i = 1; step(); stop_wr_i = 0;
            end
            blk_done_i = 1; wbuf_valid_i = (i == stop_blk);
            step();
            blk_done_i = 0;
            if (i < cnt && i == stop_blk) begin
                step();
                chk("R1 no accept while buffered", wr_active_o, 1'b1);
                chk("R1 no gap event while buffered", gap_evt_o, 1'b0);
                wbuf_valid_i = 0;
                step();
                chk("R2 wr cleared", wr_active_o, 1'b0);
                chk("R2 gap event", gap_evt_o, 1'b1);
                chk("R2 dat held", dat_active_o, 1'b1);
                wait_busy_end(busy_cyc, "R3");
                irq_clr_i = 2'b11; step(); irq_clr_i = 2'b00;
                chk("R4 stop cleared by ack", stop_req_o, 1'b0);
                chk("R9 gap flag cleared", gap_evt_o, 1'b0);
                chk("R9 cmp flag cleared", xfer_cmp_o, 1'b0);
                card_busy_i = (busy_cyc > 0);
                cont_wr_i = 1; step(); cont_wr_i = 0;
                chk("R7 continue wr", wr_active_o, 1'b1);
                chk("R7 continue dat", dat_active_o, 1'b1);
            end
        end
        wbuf_valid_i = 0;
        chk("R8 end wr cleared", wr_active_o, 1'b0);
        chk("R5 R8 no gap event at end", gap_evt_o, 1'b0);
        chk("R8 dat held at end", dat_active_o, 1'b1);
        wait_busy_end(busy_cyc, "R8");
        chk("R4 stop still pending", stop_req_o, (stop_blk == cnt) ? 1'b1 : 1'b0);
        irq_clr_i = 2'b11; step(); irq_clr_i = 2'b00;
        chk("R4 stop clear after ack", stop_req_o, 1'b0);
        chk("R9 cmp cleared", xfer_cmp_o, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        step();
        chk("R11 reset wr", wr_active_o, 1'b0);
        chk("R11 reset dat", dat_active_o, 1'b0);
        chk("R11 reset stop", stop_req_o, 1'b0);
        chk("R11 reset gap", gap_evt_o, 1'b0);
        chk("R11 reset cmp", xfer_cmp_o, 1'b0);
        rst_n = 1;
        step();

        for (int v = 0; v < NVEC; v++) run_xfer(VEC[v][0], VEC[v][1], VEC[v][2]);

        // zero count start ignored
        start_i = 1; blk_cnt_i = '0; step(); start_i = 0;
        chk("R10 zero count ignored", dat_active_o, 1'b0);

        // continue while idle ignored
        cont_wr_i = 1; step(); cont_wr_i = 0;
        chk("R6 idle continue ignored", wr_active_o, 1'b0);

        // second start while active ignored: transfer ends after 2 blocks
        start_i = 1; blk_cnt_i = 8'd2; step();
        blk_cnt_i = 8'd9; step(); start_i = 0;
        blk_done_i = 1; step(); blk_done_i = 0;
        chk("R10 still running after block 1", wr_active_o, 1'b1);
        blk_begin_i = 1; step(); blk_begin_i = 0;
        blk_done_i = 1; step(); blk_done_i = 0;
        chk("R10 restart ignored, end after 2", wr_active_o, 1'b0);
        step();
        chk("R8 idle after end", dat_active_o, 1'b0);
        irq_clr_i = 2'b11; step(); irq_clr_i = 2'b00;

        // halted with stop still 1: continue ignored; partial ack
        start_i = 1; blk_cnt_i = 8'd3; step(); start_i = 0;
        stop_wr_i = 1; stop_wdata_i = 1; step(); stop_wr_i = 0;
        blk_done_i = 1; step(); blk_done_i = 0;
        step();
        chk("R2 accepted with empty buffer", gap_evt_o, 1'b1);
        step();
        chk("R3 halted dat low", dat_active_o, 1'b0);
        irq_clr_i = 2'b01; step(); irq_clr_i = 2'b00;
        chk("R9 gap cleared alone", gap_evt_o, 1'b0);
        chk("R9 cmp untouched", xfer_cmp_o, 1'b1);
        chk("R4 stop held before cmp ack", stop_req_o, 1'b1);
        cont_wr_i = 1; step(); cont_wr_i = 0;
        chk("R6 continue ignored with stop set", wr_active_o, 1'b0);
        chk("R6 dat stays low", dat_active_o, 1'b0);
        irq_clr_i = 2'b10; step(); irq_clr_i = 2'b00;
        chk("R4 stop cleared on cmp ack", stop_req_o, 1'b0);
        cont_wr_i = 1; step(); cont_wr_i = 0;
        chk("R7 continue accepted", wr_active_o, 1'b1);
        blk_begin_i = 1; step(); blk_begin_i = 0;
        blk_done_i = 1; step(); blk_done_i = 0;
        chk("R7 one block left after block 2", wr_active_o, 1'b1);
        blk_begin_i = 1; step(); blk_begin_i = 0;
        blk_done_i = 1; step(); blk_done_i = 0;
        chk("R7 ends after remaining blocks", wr_active_o, 1'b0);
        step();
        chk("R8 final dat low", dat_active_o, 1'b0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule